// File: doc/BRIEF.md
# Multichannel Count Frame SPI Readout

This block sits between four reciprocal counter channels and an external microcontroller. At the end of every counting period the channels present their two 32-bit results at once, with one shared valid strobe: the number of input-signal edges and the number of reference-clock ticks. The block takes all eight values in one system-clock edge, so a frame never mixes counts from two periods. It raises a ready flag so the microcontroller knows a fresh frame is waiting.

The microcontroller is the SPI master and reads the frame in SPI mode 0. The block is read-only. The master's MOSI line is not needed and is left unconnected. SCLK and CS_n are brought into the system clock domain by synchronisers, and the block acts on their edges. SCLK must therefore stay high for at least four system clocks and low for at least four system clocks. The master must also wait at least four system clocks after CS_n falls before the first rising SCLK edge. MISO is always driven. It is never tri-stated.

Top module: `count_frame_spi`

## Requirements
- R1: After reset, `data_ready_o` is 0 and `spi_miso_o` is 0. The stored frame is all zeros.
- R2: A frame is 256 bits and is sent most significant bit first. Channel 0 comes first and channel 3 last. Within each channel, the input count comes before the reference count. Channel c's input count is read from `sig_cnt_i[32*c +: 32]` and its reference count from `ref_cnt_i[32*c +: 32]`.
- R3: While CS_n is low, MISO holds its value while SCLK is high. MISO moves to the next frame bit within four system clocks after each falling SCLK edge. The first frame bit is on MISO before the first rising edge.
- R4: When `cnt_valid_i` is high on a clock edge while the synchronised CS_n is high, all eight counts are stored as the new frame and `data_ready_o` is 1 after that edge.
- R5: `data_ready_o` returns to 0 within four system clocks of CS_n falling. It does not fall at any other time.
- R6: A valid strobe that arrives while CS_n is low is discarded. The frame being read does not change, `data_ready_o` stays 0, and the next read returns the earlier frame again.
- R7: If CS_n rises before all 256 bits are read, the rest of the frame is dropped. The next read starts again from channel 0's input count of the same stored frame.
- R8: SCLK cycles beyond the 256th return 0 on MISO.
- R9: Several valid strobes while CS_n is high keep `data_ready_o` at 1, and the latest counts replace earlier ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sig_cnt_i | input | NUM_CH*CNT_W | Input-signal counts, channel c in bits 32c+31..32c |
| ref_cnt_i | input | NUM_CH*CNT_W | Reference-clock counts, same packing |
| cnt_valid_i | input | 1 | One-cycle strobe, all counts are final |
| spi_sclk_i | input | 1 | SPI clock from the master (mode 0) |
| spi_cs_n_i | input | 1 | SPI chip select, active low |
| spi_miso_o | output | 1 | Serial frame data to the master |
| data_ready_o | output | 1 | A frame has been stored and not yet selected |

## Verification
A wrong slice position or a wrong channel order in the frame shows up as a bit mismatch inside the first 256-bit read that follows a load. Distinct per-channel patterns point to the exact channel and word. A broken edge detector or shift enable shows at the next falling SCLK edge: MISO either lags a bit or advances twice, and every later bit of the read is wrong. A stale or missing restart of the shift register only shows on the read after an aborted or overlong transfer. The ready flag needs two checks because a wrong value shows at different times: a missing clear appears within four clocks of CS_n falling, and a wrongly accepted strobe during a read appears after CS_n rises.

// File: rtl/cfs_pkg.sv
// Package: shared constants and helpers for the count frame SPI readout.
// Assumes at least two synchroniser stages for asynchronous SPI pins.
package cfs_pkg;

    // Number of flops used to bring SPI pins into the system clock domain.
    localparam int unsigned CFS_SYNC_STAGES = 2;

    // Frame length in bits: two counts per channel.
    function automatic int unsigned cfs_frame_bits(input int unsigned num_ch,
                                                   input int unsigned cnt_w);
        return 2 * num_ch * cnt_w;
    endfunction

endpackage

// File: rtl/cfs_edge_sync.sv
// cfs_edge_sync: brings one asynchronous pin into the clk domain and
// reports its synchronised level and its falling edge.
// Assumes the pin holds each level for more than STAGES+1 clock cycles.
module cfs_edge_sync #(
    parameter int unsigned STAGES  = cfs_pkg::CFS_SYNC_STAGES,
    parameter logic        RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o,
    output logic fall_o
);

    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Shift the pin through the synchroniser and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= {STAGES{RST_VAL}};
            last_q <= RST_VAL;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    // Present the synchronised level and the high-to-low transition.
    always_comb begin
        level_o = sync_q[STAGES-1];
        fall_o  = last_q & ~sync_q[STAGES-1];
    end

endmodule

// File: rtl/cfs_snapshot.sv
// cfs_snapshot: packs all channel counts into one frame and stores it when
// the counters strobe valid while no transfer is in progress. It also owns
// the data-ready flag. Assumes cs_idle_i/cs_fall_i come from a synchroniser.
module cfs_snapshot #(
    parameter int unsigned NUM_CH  = 4,
    parameter int unsigned CNT_W   = 32,
    parameter int unsigned FRAME_W = cfs_pkg::cfs_frame_bits(NUM_CH, CNT_W)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_CH*CNT_W-1:0]   sig_cnt_i,
    input  logic [NUM_CH*CNT_W-1:0]   ref_cnt_i,
    input  logic                      valid_i,
    input  logic                      cs_idle_i,
    input  logic                      cs_fall_i,
    output logic [FRAME_W-1:0]        snap_o,
    output logic                      ready_o
);

    localparam int unsigned PAIR_W = 2 * CNT_W;

    logic [FRAME_W-1:0] frame_d;
    logic [FRAME_W-1:0] snap_q;
    logic               ready_q;
    logic               take;

    // Place channel 0 at the top of the frame, input count ahead of reference.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_pack
        assign frame_d[FRAME_W-1-c*PAIR_W -: CNT_W]       = sig_cnt_i[c*CNT_W +: CNT_W];
        assign frame_d[FRAME_W-1-c*PAIR_W-CNT_W -: CNT_W] = ref_cnt_i[c*CNT_W +: CNT_W];
    end

    // A capture is allowed only between transfers.
    always_comb take = valid_i & cs_idle_i;

    // Hold the coherent frame of all channels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_q <= '0;
        end else if (take) begin
            snap_q <= frame_d;
        end
    end

    // Raise ready on capture, drop it when the master selects the block.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_q <= 1'b0;
        end else if (take) begin
            ready_q <= 1'b1;
        end else if (cs_fall_i) begin
            ready_q <= 1'b0;
        end
    end

    assign snap_o  = snap_q;
    assign ready_o = ready_q;

    // A transfer in progress freezes the stored frame.
    assert_snap_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_idle_i |=> $stable(snap_q));

    // Selecting the block clears the ready flag on the next edge.
    assert_ready_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_fall_i |=> !ready_o);

    // Ready only rises after an accepted valid strobe.
    assert_ready_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_o) |-> $past(valid_i && cs_idle_i));

endmodule

// File: rtl/cfs_shifter.sv
// cfs_shifter: parallel-in serial-out register for the SPI frame. It reloads
// from the stored frame on every clock while deselected and shifts one bit
// on each falling SCLK edge while selected, filling with zeros.
// Assumes the SCLK edge flag is one clock wide.
module cfs_shifter #(
    parameter int unsigned FRAME_W = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [FRAME_W-1:0] snap_i,
    input  logic               cs_idle_i,
    input  logic               sclk_fall_i,
    output logic               miso_o
);

    logic [FRAME_W-1:0] shreg_q;

    // Reload between transfers, advance on SCLK falling edges during one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q <= '0;
        end else if (cs_idle_i) begin
            shreg_q <= snap_i;
        end else if (sclk_fall_i) begin
            shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
        end
    end

    // The most significant bit is always the one on the wire.
    assign miso_o = shreg_q[FRAME_W-1];

    // Each falling SCLK edge presents the following frame bit.
    assert_shift_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_idle_i && sclk_fall_i) |=> (miso_o == $past(shreg_q[FRAME_W-2])));

    // Without a falling edge the wire does not move during a transfer.
    assert_miso_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_idle_i && !sclk_fall_i) |=> $stable(miso_o));

    // Between transfers the frame restarts from its first bit.
    assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_idle_i |=> (shreg_q == $past(snap_i)));

endmodule

// File: rtl/count_frame_spi.sv
// count_frame_spi: top level. It stores a coherent frame of all channel
// counts and serves it to an SPI mode 0 master, MSB first.
// Assumes SCLK high and low phases of at least four clk cycles each.
module count_frame_spi #(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned CNT_W  = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH*CNT_W-1:0] sig_cnt_i,
    input  logic [NUM_CH*CNT_W-1:0] ref_cnt_i,
    input  logic                    cnt_valid_i,
    input  logic                    spi_sclk_i,
    input  logic                    spi_cs_n_i,
    output logic                    spi_miso_o,
    output logic                    data_ready_o
);

    localparam int unsigned FRAME_W = cfs_pkg::cfs_frame_bits(NUM_CH, CNT_W);

    logic               sclk_level;
    logic               sclk_fall;
    logic               cs_idle;
    logic               cs_fall;
    logic [FRAME_W-1:0] snap;

    // Synchronise SCLK, idle low.
    cfs_edge_sync #(.RST_VAL(1'b0)) u_sclk_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (spi_sclk_i),
        .level_o (sclk_level),
        .fall_o  (sclk_fall)
    );

    // Synchronise CS_n, idle high (deselected).
    cfs_edge_sync #(.RST_VAL(1'b1)) u_cs_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (spi_cs_n_i),
        .level_o (cs_idle),
        .fall_o  (cs_fall)
    );

    cfs_snapshot #(
        .NUM_CH  (NUM_CH),
        .CNT_W   (CNT_W),
        .FRAME_W (FRAME_W)
    ) u_snapshot (
        .clk       (clk),
        .rst_n     (rst_n),
        .sig_cnt_i (sig_cnt_i),
        .ref_cnt_i (ref_cnt_i),
        .valid_i   (cnt_valid_i),
        .cs_idle_i (cs_idle),
        .cs_fall_i (cs_fall),
        .snap_o    (snap),
        .ready_o   (data_ready_o)
    );

    cfs_shifter #(
        .FRAME_W (FRAME_W)
    ) u_shifter (
        .clk         (clk),
        .rst_n       (rst_n),
        .snap_i      (snap),
        .cs_idle_i   (cs_idle),
        .sclk_fall_i (sclk_fall),
        .miso_o      (spi_miso_o)
    );

    // While the synchronised SCLK is high inside a transfer, MISO holds.
    assert_miso_high_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_idle && sclk_level) |=> $stable(spi_miso_o));

endmodule

// File: tb/count_frame_spi_bench.sv
// Directed bench for count_frame_spi: one task per scenario, each checking
// its own results against frames built from the requirements.
module count_frame_spi_bench;

    localparam int NCH  = 4;
    localparam int CW   = 32;
    localparam int FW   = 2 * NCH * CW;
    localparam int HALF = 8;   // SCLK half period in clk cycles

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH*CW-1:0] sig_cnt = '0;
    logic [NCH*CW-1:0] ref_cnt = '0;
    logic            cnt_valid = 1'b0;
    logic            sclk = 1'b0;
    logic            cs_n = 1'b1;
    logic            miso;
    logic            ready;

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [CW-1:0] s_a [NCH];
    logic [CW-1:0] r_a [NCH];

    always #2 clk = ~clk;   // 250 MHz

    count_frame_spi u_count_frame_spi (
        .clk          (clk),
        .rst_n        (rst_n),
        .sig_cnt_i    (sig_cnt),
        .ref_cnt_i    (ref_cnt),
        .cnt_valid_i  (cnt_valid),
        .spi_sclk_i   (sclk),
        .spi_cs_n_i   (cs_n),
        .spi_miso_o   (miso),
        .data_ready_o (ready)
    );

    task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected frame per R2: channel 0 first, input count before reference.
    function automatic logic [FW-1:0] exp_frame();
        logic [FW-1:0] f;
        for (int c = 0; c < NCH; c++) begin
            f[FW-1-64*c -: CW]    = s_a[c];
            f[FW-1-64*c-CW -: CW] = r_a[c];
        end
        return f;
    endfunction

    // Put a pattern on the count inputs without strobing valid.
    task automatic set_data(input logic [CW-1:0] seed);
        @(negedge clk);
        for (int c = 0; c < NCH; c++) begin
            s_a[c] = seed ^ (32'h1111_0000 * (c + 1)) ^ (c * 7);
            r_a[c] = ~seed + (32'h0101_0101 * (c + 3));
            sig_cnt[c*CW +: CW] = s_a[c];
            ref_cnt[c*CW +: CW] = r_a[c];
        end
    endtask

    task automatic strobe();
        @(negedge clk);
        cnt_valid = 1'b1;
        @(negedge clk);
        cnt_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Run one SPI transfer of nbits; optionally strobe valid mid-transfer.
    task automatic spi_xfer(input int nbits, input bit poke, output logic [511:0] got);
        got = '0;
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        if (poke) begin
            cnt_valid = 1'b1;
            @(negedge clk);
            cnt_valid = 1'b0;
        end
        for (int i = 0; i < nbits; i++) begin
            repeat (HALF) @(negedge clk);
            got = {got[510:0], miso};
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 ready after reset", {511'd0, ready}, 512'd0);
        check("R1 miso after reset", {511'd0, miso}, 512'd0);
    endtask

    task automatic t_basic(input logic [CW-1:0] seed);
        logic [511:0] got;
        set_data(seed);
        strobe();
        check("R4 ready after capture", {511'd0, ready}, 512'd1);
        spi_xfer(FW, 1'b0, got);
        check("R2 frame content", got, {256'd0, exp_frame()});
        check("R5 ready after read", {511'd0, ready}, 512'd0);
    endtask

    task automatic t_ready_clear();
        set_data(32'h0BAD_F00D);
        strobe();
        check("R5 ready set before select", {511'd0, ready}, 512'd1);
        @(negedge clk);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R5 ready cleared within 4 clocks", {511'd0, ready}, 512'd0);
        cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
        check("R5 ready stays low after deselect", {511'd0, ready}, 512'd0);
    endtask

    task automatic t_timing();
        logic [FW-1:0] f;
        set_data(32'hA5C3_3C5A);
        strobe();
        f = exp_frame();
        @(negedge clk);
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        check("R3 first bit before first rise", {511'd0, miso}, {511'd0, f[FW-1]});
        sclk = 1'b1;
        repeat (HALF - 1) @(negedge clk);
        check("R3 miso held while sclk high", {511'd0, miso}, {511'd0, f[FW-1]});
        @(negedge clk);
        sclk = 1'b0;
        repeat (4) @(negedge clk);
        check("R3 next bit within 4 clocks of fall", {511'd0, miso}, {511'd0, f[FW-2]});
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic t_busy_ignore();
        logic [511:0] got;
        logic [FW-1:0] old_f;
        set_data(32'h1234_5678);
        strobe();
        old_f = exp_frame();
        set_data(32'hFEDC_BA98);     // new counts arrive during the read
        spi_xfer(FW, 1'b1, got);
        check("R6 frame unchanged by busy strobe", got, {256'd0, old_f});
        check("R6 ready stays low", {511'd0, ready}, 512'd0);
        spi_xfer(FW, 1'b0, got);
        check("R6 reread gives earlier frame", got, {256'd0, old_f});
    endtask

    task automatic t_abort();
        logic [511:0] got;
        logic [FW-1:0] f;
        set_data(32'h7E57_0001);
        strobe();
        f = exp_frame();
        spi_xfer(70, 1'b0, got);
        check("R7 partial read prefix", got, {442'd0, f[FW-1 -: 70]});
        spi_xfer(FW, 1'b0, got);
        check("R7 restart from channel 0", got, {256'd0, f});
    endtask

    task automatic t_tail();
        logic [511:0] got;
        logic [FW-1:0] f;
        set_data(32'hFFFF_FFFF);
        strobe();
        f = exp_frame();
        spi_xfer(FW + 8, 1'b0, got);
        check("R8 frame before tail", {256'd0, got[FW+7:8]}, {256'd0, f});
        check("R8 zeros after frame", {504'd0, got[7:0]}, 512'd0);
    endtask

    task automatic t_latest();
        logic [511:0] got;
        set_data(32'h0000_0001);
        strobe();
        check("R9 ready after first strobe", {511'd0, ready}, 512'd1);
        set_data(32'h5555_AAAA);
        strobe();
        check("R9 ready after second strobe", {511'd0, ready}, 512'd1);
        spi_xfer(FW, 1'b0, got);
        check("R9 latest counts win", got, {256'd0, exp_frame()});
    endtask

    // Watchdog: a hung run is counted as a failure and still summarised.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin
            s_a[c] = '0;
            r_a[c] = '0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_reset();
        t_basic(32'hDEAD_BEEF);
        t_basic(32'h0000_0000);
        t_ready_clear();
        t_timing();
        t_busy_ignore();
        t_abort();
        t_tail();
        t_latest();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule